// File: doc/BRIEF.md
# Dual-Edge PDM Microphone Capture Front End

This block turns a fast system clock into a PDM bus clock for digital microphones and collects the single-bit pulse-density streams those microphones return. Up to four microphones are supported on two data pins. Each pin carries two microphones: one drives its data while the bus clock is high, and the other drives it while the clock is low. The block therefore samples each pin on both bus clock edges and routes each sample to the channel that owns that edge.

The bus clock comes from two cascaded 8-bit dividers. The first divider turns the system clock into a main tick rate. The second divider turns the main tick into bus clock edges. Both bus clock edges are produced inside the system clock domain as one-cycle strobes, so the block has no second clock domain. Every captured bit leaves the block with a one-cycle valid pulse, ready for a decimation filter downstream.

Top module: `pdm_cap_top`

## Requirements
- R1: While all four bits of `ch_en_i` are 0, `pdm_clk_o` is held at 0 and every `ch_vld_o` and `ch_bit_o` bit is 0.
- R2: While at least one channel is enabled, `pdm_clk_o` toggles once every (`main_div_i`+1)*(`bus_div_i`+1) system clock cycles. After the block leaves the all-disabled state, the first rising edge comes that many cycles after the enables are applied.
- R3: Channels 0 and 1 take their data from `pdm_dat_i[0]`. Channels 2 and 3 take their data from `pdm_dat_i[1]`. Channel index n sits at bit n of `ch_en_i`, `ch_bit_o` and `ch_vld_o`.
- R4: When the swap bit of a pair is 0, the even channel captures on falling bus clock edges and the odd channel captures on rising bus clock edges. `edge_swap_i[0]` controls channels 0/1, and `edge_swap_i[1]` controls channels 2/3.
- R5: When the swap bit of a pair is 1, the even channel captures on rising edges and the odd channel captures on falling edges.
- R6: For each bus clock edge that a channel owns, that channel's `ch_vld_o` is high for exactly one system cycle. This is the cycle after the cycle in which the edge first appears on `pdm_clk_o`. During that valid cycle, `ch_bit_o` carries the pin value that was present at the system clock edge ending the edge cycle.
- R7: A disabled channel keeps its `ch_vld_o` and `ch_bit_o` at 0, while the other channels keep capturing normally.
- R8: Divider values of 0 divide by one. With both dividers at 0, `pdm_clk_o` toggles every system cycle and both channels of a pair still capture on alternate cycles.
- R9: While `rst_ni` is low, `pdm_clk_o`, `ch_bit_o` and `ch_vld_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_div_i | input | 8 | First divider value; the main tick rate is the system clock divided by value+1 |
| bus_div_i | input | 8 | Second divider value; a bus clock edge occurs every value+1 main ticks |
| ch_en_i | input | 4 | Per-channel enable |
| edge_swap_i | input | 2 | Per-pair edge swap: bit 0 for channels 0/1, bit 1 for channels 2/3 |
| pdm_dat_i | input | 2 | Microphone data pins |
| pdm_clk_o | output | 1 | PDM bus clock |
| ch_bit_o | output | 4 | Last captured bit per channel |
| ch_vld_o | output | 4 | One-cycle strobe per captured bit |

## Verification
The assertions assume the following about the inputs:
- Each enable set is applied cleanly.
- The dividers stay fixed while the bus clock runs, so every bus edge is separated from the next by at least one system cycle.
- The data pins are already synchronous to `clk_i`.

The stimulus follows these assumptions. It changes dividers and swap bits only while every channel is disabled. It drives the pins only at falling system clock edges, and only right after a bus clock edge is seen on `pdm_clk_o`, in the way a microphone drives its slot. Against this stimulus, the bench models which channel owns each edge and which pin value it must capture.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;
  localparam int unsigned NUM_PAIR = 2;
  localparam int unsigned CH_PER_PAIR = 2;
  localparam int unsigned NUM_CH = NUM_PAIR * CH_PER_PAIR;
  localparam int unsigned DIV_W = 8;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_stb_t;
endpackage

// File: rtl/pdm_tick_div.sv
module pdm_tick_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = cnt_q >= lim_i;
  assign tick_o = run_i & step_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pdm_edge_gen.sv
module pdm_edge_gen
  import pdm_cap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      tick_i,
  output logic      bclk_o,
  output edge_stb_t stb_o
);
  logic      bclk_q;
  edge_stb_t stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      stb_q  <= '0;
    end else if (!run_i) begin
      bclk_q <= 1'b0;
      stb_q  <= '0;
    end else begin
      stb_q.rise <= tick_i & ~bclk_q;
      stb_q.fall <= tick_i & bclk_q;
      if (tick_i) bclk_q <= ~bclk_q;
    end
  end

  assign bclk_o = bclk_q;
  assign stb_o  = stb_q;
endmodule

// File: rtl/pdm_pair_cap.sv
module pdm_pair_cap
  import pdm_cap_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   dat_i,
  input  logic                   swap_i,
  input  logic [CH_PER_PAIR-1:0] en_i,
  input  edge_stb_t              stb_i,
  output logic [CH_PER_PAIR-1:0] bit_o,
  output logic [CH_PER_PAIR-1:0] vld_o
);
  logic [CH_PER_PAIR-1:0] take;
  logic [CH_PER_PAIR-1:0] bit_q, vld_q;

  // even slot owns the falling edge unless swapped
  assign take[0] = swap_i ? stb_i.rise : stb_i.fall;
  assign take[1] = swap_i ? stb_i.fall : stb_i.rise;

  for (genvar c = 0; c < CH_PER_PAIR; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q[c] <= 1'b0;
        vld_q[c] <= 1'b0;
      end else if (!en_i[c]) begin
        bit_q[c] <= 1'b0;
        vld_q[c] <= 1'b0;
      end else begin
        vld_q[c] <= take[c];
        if (take[c]) bit_q[c] <= dat_i;
      end
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/pdm_cap_top.sv
module pdm_cap_top
  import pdm_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  main_div_i,
  input  logic [DIV_W-1:0]  bus_div_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_PAIR-1:0] edge_swap_i,
  input  logic [NUM_PAIR-1:0] pdm_dat_i,
  output logic              pdm_clk_o,
  output logic [NUM_CH-1:0] ch_bit_o,
  output logic [NUM_CH-1:0] ch_vld_o
);
  logic      run;
  logic      main_tick;
  logic      edge_tick;
  edge_stb_t stb;

  assign run = |ch_en_i;

  pdm_tick_div #(.W(DIV_W)) u_main_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .step_i(1'b1),
    .lim_i (main_div_i),
    .tick_o(main_tick)
  );

  pdm_tick_div #(.W(DIV_W)) u_bus_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .step_i(main_tick),
    .lim_i (bus_div_i),
    .tick_o(edge_tick)
  );

  pdm_edge_gen u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_i(edge_tick),
    .bclk_o(pdm_clk_o),
    .stb_o (stb)
  );

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    pdm_pair_cap u_pair (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .dat_i (pdm_dat_i[p]),
      .swap_i(edge_swap_i[p]),
      .en_i  (ch_en_i[p*CH_PER_PAIR +: CH_PER_PAIR]),
      .stb_i (stb),
      .bit_o (ch_bit_o[p*CH_PER_PAIR +: CH_PER_PAIR]),
      .vld_o (ch_vld_o[p*CH_PER_PAIR +: CH_PER_PAIR])
    );
  end
endmodule

// File: rtl/pdm_cap_chk.sv
module pdm_cap_chk
  import pdm_cap_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] ch_en_i,
  input logic              pdm_clk_o,
  input logic [NUM_CH-1:0] ch_vld_o
);
  assert_idle_clk_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_en_i == '0) |=> (!pdm_clk_o && ch_vld_o == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assert_vld_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_vld_o[i] |=> !ch_vld_o[i]);
    assert_vld_after_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_vld_o[i] |-> ($past(pdm_clk_o) != $past(pdm_clk_o, 2)));
    assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en_i[i] |=> !ch_vld_o[i]);
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    assert_pair_one_owner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(ch_vld_o[p*CH_PER_PAIR +: CH_PER_PAIR]) <= 1);
  end
endmodule

bind pdm_cap_top pdm_cap_chk u_pdm_cap_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ch_en_i  (ch_en_i),
  .pdm_clk_o(pdm_clk_o),
  .ch_vld_o (ch_vld_o)
);

// File: tb/pdm_cap_top_bench.sv
`timescale 1ns/1ps
module pdm_cap_top_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] main_div_i = '0;
  logic [7:0] bus_div_i = '0;
  logic [3:0] ch_en_i = '0;
  logic [1:0] edge_swap_i = '0;
  logic [1:0] pdm_dat_i = '0;
  logic       pdm_clk_o;
  logic [3:0] ch_bit_o, ch_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  pdm_cap_top u_pdm_cap_top (.*);

  typedef struct packed {
    logic [7:0]  md;
    logic [7:0]  bd;
    logic [3:0]  en;
    logic [1:0]  sw;
    logic [31:0] half;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{md: 8'd1,   bd: 8'd1, en: 4'hF, sw: 2'b00, half: 32'd4},
    '{md: 8'd1,   bd: 8'd1, en: 4'hF, sw: 2'b11, half: 32'd4},
    '{md: 8'd0,   bd: 8'd0, en: 4'hF, sw: 2'b01, half: 32'd1},
    '{md: 8'd3,   bd: 8'd2, en: 4'h5, sw: 2'b10, half: 32'd12},
    '{md: 8'd0,   bd: 8'd7, en: 4'hA, sw: 2'b00, half: 32'd8},
    '{md: 8'd255, bd: 8'd0, en: 4'h3, sw: 2'b01, half: 32'd256}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_check();
    ch_en_i = '0;
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      check(pdm_clk_o == 1'b0, "R1", "bus clock idle", pdm_clk_o, 0);
      check(ch_vld_o == '0 && ch_bit_o == '0, "R1", "outputs idle",
            {ch_vld_o, ch_bit_o}, 0);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [3:0] pv, pb;
    logic       prev;
    int         cnt, tog;
    main_div_i = v.md;
    bus_div_i = v.bd;
    edge_swap_i = v.sw;
    @(negedge clk_i);
    ch_en_i = v.en;
    pv = '0; pb = '0; prev = 1'b0; cnt = 0; tog = 0;
    while (tog < 24) begin
      @(negedge clk_i);
      cnt++;
      for (int c = 0; c < 4; c++) begin
        if (!v.en[c]) begin
          // R7: disabled channel silent
          check(!ch_vld_o[c] && !ch_bit_o[c], "R7", $sformatf("ch%0d disabled", c),
                {ch_vld_o[c], ch_bit_o[c]}, 0);
        end else begin
          // R4 R5 R6: ownership and strobe timing
          check(ch_vld_o[c] == pv[c], "R4 R5 R6", $sformatf("ch%0d valid", c),
                ch_vld_o[c], pv[c]);
          if (pv[c])
            check(ch_bit_o[c] == pb[c], "R3 R6", $sformatf("ch%0d bit", c),
                  ch_bit_o[c], pb[c]);
        end
      end
      pv = '0;
      if (pdm_clk_o != prev) begin
        check(cnt == v.half, (v.half == 1) ? "R8" : "R2", "half period",
              cnt, v.half);
        cnt = 0;
        tog++;
        prev = pdm_clk_o;
        pdm_dat_i = 2'($urandom);
        for (int c = 0; c < 4; c++) begin
          bit owns;
          owns = (c % 2 == 0) ? (pdm_clk_o == v.sw[c/2]) : (pdm_clk_o != v.sw[c/2]);
          pv[c] = v.en[c] & owns;
          pb[c] = pdm_dat_i[c/2];
        end
      end else if (cnt > v.half + 2) begin
        check(1'b0, "R2", "bus clock stalled", cnt, v.half);
        break;
      end
    end
    idle_check();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(pdm_clk_o == 0 && ch_vld_o == 0 && ch_bit_o == 0, "R9", "reset state",
          {pdm_clk_o, ch_vld_o, ch_bit_o}, 0);
    rst_ni = 1'b1;
    idle_check();

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R9: reset in mid-run clears everything
    main_div_i = 8'd0; bus_div_i = 8'd0; edge_swap_i = 2'b00;
    pdm_dat_i = 2'b11;
    @(negedge clk_i);
    ch_en_i = 4'hF;
    repeat (6) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(pdm_clk_o == 0 && ch_vld_o == 0 && ch_bit_o == 0, "R9", "reset mid-run",
          {pdm_clk_o, ch_vld_o, ch_bit_o}, 0);
    @(negedge clk_i);
    check(pdm_clk_o == 0 && ch_vld_o == 0 && ch_bit_o == 0, "R9", "held in reset",
          {pdm_clk_o, ch_vld_o, ch_bit_o}, 0);
    ch_en_i = '0;
    rst_ni = 1'b1;
    idle_check();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule